// File: doc/BRIEF.md
# Command/Response Byte FIFO Controller

This block moves one command and one response between a host and a backend engine. The host sees two registers: a 32-bit status word and a one-byte data port. Command bytes written to the data port collect in a local buffer. A big-endian length field carried inside the command tells the block when the command is complete. On a go request the block starts the backend through a start/done handshake. The backend reads the command bytes and writes its response into a shared buffer. The host then drains the response through the same data port.

A five-state controller (idle, ready, reception, execution, completion) decides what each register access does. The status word reports how many bytes may be moved next and four flags: valid, command-ready, data-available and expect. Single-cycle event pulses mark command-ready, status-valid and data-available transitions so that an interrupt block outside can use them.

Top module: `cmdrsp_fifo`

## Requirements
- R1: After reset the controller is idle, the status flag bits (valid bit 7, command-ready bit 6, data-available bit 4, expect bit 3) are all zero, both offsets are zero and no event pulses.
- R2: A command-ready request (status write with exactly bit 6 set) in idle moves to ready, sets command-ready and pulses the command-ready event. In ready it only clears both offsets and raises no event.
- R3: A command-ready request in completion clears both offsets, clears data-available, moves to ready, and sets command-ready with an event only when it was not already set.
- R4: A data-port write in ready moves to reception with status expect plus valid and stores the byte. Data-port writes in idle, execution and completion change nothing.
- R5: While expect is set each written byte goes to the write offset, which then advances. Once more than 5 bytes are held, bytes 2..5 (byte 2 most significant) form the command length, and expect stays set only while that length exceeds the write offset. Bytes written with expect clear are not stored.
- R6: A data-port write while expect is set and the buffer is full stores nothing and leaves valid as the only flag.
- R7: A go request (status write with exactly bit 5 set) acts only in reception with expect clear. It moves to execution and pulses the backend start output for one cycle.
- R8: On backend done in execution with no abort pending, status becomes valid plus data-available, the state moves to completion, both offsets clear, and the data-available and status-valid events pulse.
- R9: A data-port read in completion with data-available set returns the response byte at the read offset and advances it. When the offset reaches the response length (response bytes 2..5, big-endian), only valid remains and the status-valid event pulses. Every other data-port read returns 0xFF.
- R10: The burst count in status bits 8 and up equals the response length minus the read offset while data-available is set. Otherwise it equals the buffer depth minus the write offset, clamped to 255 on a single-byte access.
- R11: A response-retry request (status write with exactly bit 1 set) in completion clears the read offset and restores valid plus data-available; in any other state it has no effect.
- R12: A status write acts only when exactly one of bits 6, 5 and 1 is set; other bits are ignored.
- R13: A command-ready request in reception aborts at once: the state returns to ready with command-ready set, both offsets clear and the event pulses. In execution it pulses the backend cancel output once, and the next backend done returns the state to ready the same way instead of entering completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_wr_i | input | 1 | Register write strobe |
| acc_rd_i | input | 1 | Register read strobe |
| acc_sel_i | input | 1 | 0 selects the status word, 1 the data port |
| acc_byte_i | input | 1 | Current access is a single byte wide |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data for the selected register |
| be_start_o | output | 1 | One-cycle pulse that starts the backend |
| be_cancel_o | output | 1 | One-cycle pulse asking the backend to stop early |
| be_done_i | input | 1 | Backend has finished and the response is in place |
| be_cmd_raddr_i | input | AW | Backend read address into the command buffer |
| be_cmd_rdata_o | output | 8 | Command byte at that address |
| be_rsp_we_i | input | 1 | Backend write strobe into the response buffer |
| be_rsp_waddr_i | input | AW | Response buffer write address |
| be_rsp_wdata_i | input | 8 | Response byte to write |
| ev_cmd_ready_o | output | 1 | Command-ready event pulse |
| ev_sts_valid_o | output | 1 | Status-valid event pulse |
| ev_data_avail_o | output | 1 | Data-available event pulse |

## Verification
The assertions assume a well-behaved backend. It raises done only while the controller is in execution, writes the response buffer only between start and done, and returns a response length no larger than the buffer depth. The host never issues a read and a write in the same cycle. The bench keeps to these rules: its backend model waits for the start pulse before it writes a 10-byte response and then pulses done once. Every host access lasts one cycle with a free cycle after it.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_READY, ST_RECV, ST_EXEC, ST_CMPL} state_e;

  // status and request bit positions, decoded by host software
  localparam int BIT_VLD   = 7;
  localparam int BIT_RDY   = 6;
  localparam int BIT_GO    = 5;
  localparam int BIT_AVL   = 4;
  localparam int BIT_XPC   = 3;
  localparam int BIT_RETRY = 1;

  typedef struct packed {
    logic vld;
    logic rdy;
    logic avl;
    logic xpc;
  } sts_t;

  localparam sts_t STS_NONE = '{vld: 1'b0, rdy: 1'b0, avl: 1'b0, xpc: 1'b0};

  function automatic logic [31:0] sts_word(sts_t s, logic [23:0] burst);
    return {burst, s.vld, s.rdy, 1'b0, s.avl, s.xpc, 3'b000};
  endfunction
endpackage

// File: rtl/cmdrsp_store.sv
module cmdrsp_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          cmd_we_i,
  input  logic [AW-1:0] cmd_waddr_i,
  input  logic [7:0]    cmd_wdata_i,
  input  logic [AW-1:0] cmd_raddr_i,
  output logic [7:0]    cmd_rdata_o,
  output logic [31:0]   cmd_len_o,
  input  logic          rsp_we_i,
  input  logic [AW-1:0] rsp_waddr_i,
  input  logic [7:0]    rsp_wdata_i,
  input  logic [AW-1:0] rsp_raddr_i,
  output logic [7:0]    rsp_rdata_o,
  output logic [31:0]   rsp_len_o
);
  localparam int LEN_POS = 2;

  logic [7:0] cmd_mem [DEPTH];
  logic [7:0] rsp_mem [DEPTH];
  logic [7:0] cmd_b [4];
  logic [7:0] rsp_b [4];

  always_ff @(posedge clk_i) begin
    if (cmd_we_i) cmd_mem[cmd_waddr_i] <= cmd_wdata_i;
    if (rsp_we_i) rsp_mem[rsp_waddr_i] <= rsp_wdata_i;
  end

  // length bytes; command side sees the byte being written this cycle
  for (genvar k = 0; k < 4; k++) begin : g_len
    assign cmd_b[k] = (cmd_we_i && cmd_waddr_i == AW'(LEN_POS + k))
                      ? cmd_wdata_i : cmd_mem[LEN_POS + k];
    assign rsp_b[k] = rsp_mem[LEN_POS + k];
  end

  assign cmd_len_o   = {cmd_b[0], cmd_b[1], cmd_b[2], cmd_b[3]};
  assign rsp_len_o   = {rsp_b[0], rsp_b[1], rsp_b[2], rsp_b[3]};
  assign cmd_rdata_o = (32'(cmd_raddr_i) < DEPTH) ? cmd_mem[cmd_raddr_i] : 8'hFF;
  assign rsp_rdata_o = (32'(rsp_raddr_i) < DEPTH) ? rsp_mem[rsp_raddr_i] : 8'hFF;
endmodule

// File: rtl/cmdrsp_status.sv
module cmdrsp_status
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OW    = $clog2(DEPTH) + 1
) (
  input  sts_t          sts_i,
  input  logic [31:0]   rsp_len_i,
  input  logic [OW-1:0] rd_off_i,
  input  logic [OW-1:0] wr_off_i,
  input  logic          byte_acc_i,
  output logic [31:0]   word_o
);
  logic [31:0] room, left, burst;

  always_comb begin
    room  = 32'(DEPTH) - 32'(wr_off_i);
    left  = rsp_len_i - 32'(rd_off_i);
    if (sts_i.avl)                       burst = left;
    else if (byte_acc_i && room > 32'd255) burst = 32'd255;
    else                                 burst = room;
    word_o = sts_word(sts_i, burst[23:0]);
  end

  logic unused_hi;
  assign unused_hi = ^burst[31:24];
endmodule

// File: rtl/cmdrsp_fifo.sv
module cmdrsp_fifo
  import cmdrsp_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int OW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_wr_i,
  input  logic          acc_rd_i,
  input  logic          acc_sel_i,
  input  logic          acc_byte_i,
  input  logic [31:0]   acc_wdata_i,
  output logic [31:0]   acc_rdata_o,
  output logic          be_start_o,
  output logic          be_cancel_o,
  input  logic          be_done_i,
  input  logic [AW-1:0] be_cmd_raddr_i,
  output logic [7:0]    be_cmd_rdata_o,
  input  logic          be_rsp_we_i,
  input  logic [AW-1:0] be_rsp_waddr_i,
  input  logic [7:0]    be_rsp_wdata_i,
  output logic          ev_cmd_ready_o,
  output logic          ev_sts_valid_o,
  output logic          ev_data_avail_o
);
  localparam logic [OW-1:0] DEPTH_W = OW'(DEPTH);
  localparam sts_t STS_RDY  = '{vld: 1'b0, rdy: 1'b1, avl: 1'b0, xpc: 1'b0};
  localparam sts_t STS_VLD  = '{vld: 1'b1, rdy: 1'b0, avl: 1'b0, xpc: 1'b0};
  localparam sts_t STS_RECV = '{vld: 1'b1, rdy: 1'b0, avl: 1'b0, xpc: 1'b1};
  localparam sts_t STS_RSP  = '{vld: 1'b1, rdy: 1'b0, avl: 1'b1, xpc: 1'b0};

  state_e        state_q;
  sts_t          sts_q;
  logic [OW-1:0] wr_off_q, rd_off_q;
  logic          abort_pend_q;

  logic [31:0] cmd_len, rsp_len, sts_rdata;
  logic [7:0]  rsp_byte;
  logic [2:0]  req;
  logic        do_rdy, do_go, do_retry, sts_wr, dat_wr, dat_rd;
  logic        dw_ok, cmd_we, full_hit, rd_hit, rd_last, dw_ev;
  sts_t        sts_pre, sts_dw;
  logic [OW-1:0] wr_off_nx;

  assign sts_wr   = acc_wr_i && !acc_sel_i;
  assign dat_wr   = acc_wr_i && acc_sel_i;
  assign dat_rd   = acc_rd_i && acc_sel_i;
  assign req      = {acc_wdata_i[BIT_RDY], acc_wdata_i[BIT_GO], acc_wdata_i[BIT_RETRY]};
  assign do_rdy   = sts_wr && req == 3'b100;
  assign do_go    = sts_wr && req == 3'b010;
  assign do_retry = sts_wr && req == 3'b001;

  // data-port write path
  always_comb begin
    dw_ok     = dat_wr && (state_q == ST_READY || state_q == ST_RECV);
    sts_pre   = (state_q == ST_READY) ? STS_RECV : sts_q;
    cmd_we    = dw_ok && sts_pre.xpc && (wr_off_q < DEPTH_W);
    full_hit  = dw_ok && sts_pre.xpc && !(wr_off_q < DEPTH_W);
    wr_off_nx = wr_off_q + OW'(cmd_we);
    sts_dw    = full_hit ? STS_VLD : sts_pre;
    dw_ev     = 1'b0;
    if (wr_off_nx > OW'(5) && sts_dw.xpc) begin
      sts_dw.xpc = cmd_len > 32'(wr_off_nx);
      dw_ev      = !sts_q.vld;
    end
  end

  assign rd_hit  = dat_rd && state_q == ST_CMPL && sts_q.avl;
  assign rd_last = rd_hit && (32'(rd_off_q) + 32'd1 >= rsp_len);

  cmdrsp_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
    .clk_i       (clk_i),
    .cmd_we_i    (cmd_we),
    .cmd_waddr_i (wr_off_q[AW-1:0]),
    .cmd_wdata_i (acc_wdata_i[7:0]),
    .cmd_raddr_i (be_cmd_raddr_i),
    .cmd_rdata_o (be_cmd_rdata_o),
    .cmd_len_o   (cmd_len),
    .rsp_we_i    (be_rsp_we_i),
    .rsp_waddr_i (be_rsp_waddr_i),
    .rsp_wdata_i (be_rsp_wdata_i),
    .rsp_raddr_i (rd_off_q[AW-1:0]),
    .rsp_rdata_o (rsp_byte),
    .rsp_len_o   (rsp_len)
  );

  cmdrsp_status #(.DEPTH(DEPTH), .OW(OW)) i_status (
    .sts_i      (sts_q),
    .rsp_len_i  (rsp_len),
    .rd_off_i   (rd_off_q),
    .wr_off_i   (wr_off_q),
    .byte_acc_i (acc_byte_i),
    .word_o     (sts_rdata)
  );

  assign acc_rdata_o = acc_sel_i
                       ? {24'h0, (rd_hit && rd_off_q < DEPTH_W) ? rsp_byte : 8'hFF}
                       : sts_rdata;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q         <= ST_IDLE;
      sts_q           <= STS_NONE;
      wr_off_q        <= '0;
      rd_off_q        <= '0;
      abort_pend_q    <= 1'b0;
      be_start_o      <= 1'b0;
      be_cancel_o     <= 1'b0;
      ev_cmd_ready_o  <= 1'b0;
      ev_sts_valid_o  <= 1'b0;
      ev_data_avail_o <= 1'b0;
    end else begin
      be_start_o      <= 1'b0;
      be_cancel_o     <= 1'b0;
      ev_cmd_ready_o  <= 1'b0;
      ev_sts_valid_o  <= 1'b0;
      ev_data_avail_o <= 1'b0;
      if (state_q == ST_EXEC && be_done_i) begin
        wr_off_q     <= '0;
        rd_off_q     <= '0;
        abort_pend_q <= 1'b0;
        if (abort_pend_q || do_rdy) begin
          state_q        <= ST_READY;
          sts_q          <= STS_RDY;
          ev_cmd_ready_o <= 1'b1;
        end else begin
          state_q         <= ST_CMPL;
          sts_q           <= STS_RSP;
          ev_sts_valid_o  <= 1'b1;
          ev_data_avail_o <= 1'b1;
        end
      end else if (do_rdy) begin
        unique case (state_q)
          ST_IDLE: begin
            state_q        <= ST_READY;
            sts_q          <= STS_RDY;
            ev_cmd_ready_o <= 1'b1;
          end
          ST_READY: begin
            wr_off_q <= '0;
            rd_off_q <= '0;
          end
          ST_RECV: begin
            state_q        <= ST_READY;
            sts_q          <= STS_RDY;
            wr_off_q       <= '0;
            rd_off_q       <= '0;
            ev_cmd_ready_o <= 1'b1;
          end
          ST_EXEC: begin
            if (!abort_pend_q) begin
              abort_pend_q <= 1'b1;
              be_cancel_o  <= 1'b1;
            end
          end
          ST_CMPL: begin
            state_q  <= ST_READY;
            wr_off_q <= '0;
            rd_off_q <= '0;
            if (!sts_q.rdy) begin
              sts_q          <= STS_RDY;
              ev_cmd_ready_o <= 1'b1;
            end else begin
              sts_q.avl <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (do_go) begin
        if (state_q == ST_RECV && !sts_q.xpc) begin
          state_q    <= ST_EXEC;
          be_start_o <= 1'b1;
        end
      end else if (do_retry) begin
        if (state_q == ST_CMPL) begin
          rd_off_q <= '0;
          sts_q    <= STS_RSP;
        end
      end else if (dw_ok) begin
        state_q        <= ST_RECV;
        sts_q          <= sts_dw;
        wr_off_q       <= wr_off_nx;
        ev_sts_valid_o <= dw_ev;
      end else if (rd_hit) begin
        rd_off_q <= rd_off_q + OW'(1);
        if (rd_last) begin
          sts_q          <= STS_VLD;
          ev_sts_valid_o <= 1'b1;
        end
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^{acc_wdata_i[31:8]};
endmodule

// File: rtl/cmdrsp_fifo_chk.sv
module cmdrsp_fifo_chk
  import cmdrsp_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int OW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input state_e        state_q,
  input sts_t          sts_q,
  input logic [OW-1:0] wr_off_q,
  input logic          abort_pend_q,
  input logic          acc_wr_i,
  input logic          acc_sel_i,
  input logic          be_start_o,
  input logic          be_done_i,
  input logic          ev_cmd_ready_o
);
  AST_START_IN_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_start_o |-> state_q == ST_EXEC);  // R7
  AST_EXPECT_IN_RECV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q.xpc |-> state_q == ST_RECV);  // R5
  AST_AVAIL_IN_CMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_q.avl |-> state_q == ST_CMPL);  // R8
  AST_DONE_TO_CMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_EXEC && be_done_i && !abort_pend_q && !(acc_wr_i && !acc_sel_i))
    |=> state_q == ST_CMPL);  // R8
  AST_WR_OFF_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_off_q <= OW'(DEPTH));  // R6
  AST_IDLE_DATA_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && acc_wr_i && acc_sel_i) |=> (state_q == ST_IDLE && $stable(wr_off_q)));  // R4
  AST_CMD_EVENT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_cmd_ready_o |-> (sts_q.rdy && state_q == ST_READY));  // R2
endmodule

bind cmdrsp_fifo cmdrsp_fifo_chk #(.DEPTH(DEPTH), .OW(OW)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .state_q        (state_q),
  .sts_q          (sts_q),
  .wr_off_q       (wr_off_q),
  .abort_pend_q   (abort_pend_q),
  .acc_wr_i       (acc_wr_i),
  .acc_sel_i      (acc_sel_i),
  .be_start_o     (be_start_o),
  .be_done_i      (be_done_i),
  .ev_cmd_ready_o (ev_cmd_ready_o)
);

// File: tb/test_cmdrsp_fifo.sv
`timescale 1ns/1ps
module test_cmdrsp_fifo;
  localparam int DEPTH = 320;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          acc_wr_i = 1'b0, acc_rd_i = 1'b0, acc_sel_i = 1'b0, acc_byte_i = 1'b0;
  logic [31:0]   acc_wdata_i = '0;
  logic [31:0]   acc_rdata_o;
  logic          be_start_o, be_cancel_o;
  logic          be_done_i = 1'b0;
  logic [AW-1:0] be_cmd_raddr_i = '0;
  logic [7:0]    be_cmd_rdata_o;
  logic          be_rsp_we_i = 1'b0;
  logic [AW-1:0] be_rsp_waddr_i = '0;
  logic [7:0]    be_rsp_wdata_i = '0;
  logic          ev_cmd_ready_o, ev_sts_valid_o, ev_data_avail_o;

  always #2 clk = ~clk;

  cmdrsp_fifo #(.DEPTH(DEPTH)) i_cmdrsp_fifo (
    .clk_i(clk), .rst_ni(rst_ni),
    .acc_wr_i(acc_wr_i), .acc_rd_i(acc_rd_i), .acc_sel_i(acc_sel_i),
    .acc_byte_i(acc_byte_i), .acc_wdata_i(acc_wdata_i), .acc_rdata_o(acc_rdata_o),
    .be_start_o(be_start_o), .be_cancel_o(be_cancel_o), .be_done_i(be_done_i),
    .be_cmd_raddr_i(be_cmd_raddr_i), .be_cmd_rdata_o(be_cmd_rdata_o),
    .be_rsp_we_i(be_rsp_we_i), .be_rsp_waddr_i(be_rsp_waddr_i),
    .be_rsp_wdata_i(be_rsp_wdata_i),
    .ev_cmd_ready_o(ev_cmd_ready_o), .ev_sts_valid_o(ev_sts_valid_o),
    .ev_data_avail_o(ev_data_avail_o)
  );

  int checks = 0, failures = 0;
  int n_cr = 0, n_sv = 0, n_da = 0, n_start = 0, n_cancel = 0;
  bit finished = 1'b0;

  always @(posedge clk) begin
    if (ev_cmd_ready_o)  n_cr++;
    if (ev_sts_valid_o)  n_sv++;
    if (ev_data_avail_o) n_da++;
    if (be_start_o)      n_start++;
    if (be_cancel_o)     n_cancel++;
  end

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];

  initial forever begin
    @(negedge clk);
    #1;
    if (acc_rd_i && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (acc_rdata_o !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", t, acc_rdata_o, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", t, act, e);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    acc_wr_i = 1'b1; acc_sel_i = sel; acc_wdata_i = d;
    @(negedge clk);
    acc_wr_i = 1'b0;
  endtask

  task automatic rd(input logic sel, input logic bacc, input logic [31:0] e, input string t);
    @(negedge clk);
    acc_rd_i = 1'b1; acc_sel_i = sel; acc_byte_i = bacc;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    acc_rd_i = 1'b0; acc_byte_i = 1'b0;
  endtask

  task automatic send_cmd8();
    logic [7:0] c [8];
    c = '{8'h00, 8'hC1, 8'h00, 8'h00, 8'h00, 8'h08, 8'h5A, 8'hA5};
    for (int i = 0; i < 8; i++) wr(1'b1, {24'h0, c[i]});
  endtask

  logic [7:0] rsp [10];

  task automatic backend_reply();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      be_rsp_we_i = 1'b1; be_rsp_waddr_i = AW'(i); be_rsp_wdata_i = rsp[i];
    end
    @(negedge clk);
    be_rsp_we_i = 1'b0;
    be_done_i = 1'b1;
    @(negedge clk);
    be_done_i = 1'b0;
  endtask

  initial begin
    rsp = '{8'h80, 8'hC4, 8'h00, 8'h00, 8'h00, 8'h0A, 8'h11, 8'h22, 8'h33, 8'h44};
    tick(3);
    rst_ni = 1'b1;
    tick(2);

    // R1 reset state
    rd(1'b0, 1'b0, 32'h0001_4000, "R1 status after reset");
    rd(1'b0, 1'b1, 32'h0000_FF00, "R10 byte status clamp at reset");
    rd(1'b1, 1'b0, 32'h0000_00FF, "R9 data read in idle");
    tick(1);
    chk("R1 no events after reset", n_cr + n_sv + n_da + n_start, 0);

    // R4 data write in idle ignored
    wr(1'b1, 32'hAA);
    rd(1'b0, 1'b0, 32'h0001_4000, "R4 idle data write ignored");

    // R2 idle -> ready
    wr(1'b0, 32'h40);
    rd(1'b0, 1'b0, 32'h0001_4040, "R2 command-ready in idle");
    chk("R2 command-ready event", n_cr, 1);
    wr(1'b0, 32'h40);
    tick(1);
    chk("R2 no event in ready", n_cr, 1);
    wr(1'b0, 32'h60);
    rd(1'b0, 1'b0, 32'h0001_4040, "R12 two request bits ignored");

    // R4 R5 reception
    wr(1'b1, 32'h00);
    rd(1'b0, 1'b0, 32'h0001_3F88, "R4 first byte enters reception");
    wr(1'b1, 32'hC1); wr(1'b1, 32'h00); wr(1'b1, 32'h00);
    rd(1'b0, 1'b0, 32'h0001_3C88, "R5 four bytes held");
    wr(1'b0, 32'h20);
    tick(1);
    chk("R7 go ignored while expect set", n_start, 0);
    wr(1'b1, 32'h00); wr(1'b1, 32'h08);
    rd(1'b0, 1'b0, 32'h0001_3A88, "R5 length exceeds offset");
    wr(1'b1, 32'h5A); wr(1'b1, 32'hA5);
    rd(1'b0, 1'b0, 32'h0001_3880, "R5 expect clears at length");
    wr(1'b1, 32'h77);
    rd(1'b0, 1'b0, 32'h0001_3880, "R5 byte after end not stored");
    wr(1'b0, 32'h22);
    tick(1);
    chk("R12 go plus retry ignored", n_start, 0);

    // R7 go
    wr(1'b0, 32'h20);
    tick(1);
    chk("R7 start pulse", n_start, 1);
    rd(1'b1, 1'b0, 32'h0000_00FF, "R9 data read in execution");
    wr(1'b1, 32'h99);
    rd(1'b0, 1'b0, 32'h0001_3880, "R4 execution data write ignored");
    be_cmd_raddr_i = AW'(1);
    tick(1);
    chk("R7 backend sees command byte", {24'h0, be_cmd_rdata_o}, 32'hC1);

    // R8 completion
    backend_reply();
    rd(1'b0, 1'b0, 32'h0000_0A90, "R8 status after done");
    chk("R8 data-available event", n_da, 1);
    chk("R8 status-valid event", n_sv, 1);
    wr(1'b1, 32'h55);
    rd(1'b0, 1'b0, 32'h0000_0A90, "R4 completion data write ignored");

    // R9 R10 response drain
    for (int i = 0; i < 10; i++) begin
      rd(1'b1, 1'b0, {24'h0, rsp[i]}, "R9 response byte");
      if (i == 0) rd(1'b0, 1'b0, 32'h0000_0990, "R10 burst after one read");
    end
    rd(1'b0, 1'b0, 32'h0001_4080, "R9 valid only after drain");
    rd(1'b0, 1'b1, 32'h0000_FF80, "R10 byte clamp after drain");
    rd(1'b1, 1'b0, 32'h0000_00FF, "R9 read past end");
    tick(1);
    chk("R9 status-valid event at end", n_sv, 2);

    // R11 retry
    wr(1'b0, 32'h02);
    rd(1'b0, 1'b0, 32'h0000_0A90, "R11 retry restores data");
    rd(1'b1, 1'b0, 32'h0000_0080, "R11 first byte again");

    // R3 command-ready in completion
    wr(1'b0, 32'h40);
    rd(1'b0, 1'b0, 32'h0001_4040, "R3 completion to ready");
    chk("R3 command-ready event", n_cr, 2);

    // R13 abort in reception
    wr(1'b1, 32'h00); wr(1'b1, 32'h01);
    wr(1'b0, 32'h40);
    rd(1'b0, 1'b0, 32'h0001_4040, "R13 abort in reception");
    chk("R13 event on reception abort", n_cr, 3);

    // R13 abort in execution
    send_cmd8();
    wr(1'b0, 32'h20);
    wr(1'b0, 32'h40);
    tick(1);
    chk("R13 cancel pulse", n_cancel, 1);
    rd(1'b0, 1'b0, 32'h0001_3880, "R13 still executing");
    backend_reply();
    rd(1'b0, 1'b0, 32'h0001_4040, "R13 done after abort gives ready");
    chk("R13 event after aborted done", n_cr, 4);
    chk("R13 no data-available event", n_da, 1);

    // R11 retry outside completion ignored
    wr(1'b0, 32'h02);
    rd(1'b0, 1'b0, 32'h0001_4040, "R11 retry in ready ignored");

    // R6 buffer full
    for (int i = 0; i < DEPTH; i++)
      wr(1'b1, (i == 4 || i == 5) ? 32'hFF : 32'h00);
    rd(1'b0, 1'b0, 32'h0000_0088, "R6 buffer full expect held");
    wr(1'b1, 32'h12);
    rd(1'b0, 1'b0, 32'h0000_0080, "R6 write when full clears expect");

    tick(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule